// File: doc/BRIEF.md
# Mode-Configurable Convolution Post-Processing Lane

This block is one compute lane of a small neural-network accelerator. It takes a stream of window and kernel element pairs, one pair per handshake beat, and emits a stream of result elements. A 4-bit mode word turns on four stages, each on its own. The stages are a multiply-accumulate convolution, addition of an accumulation operand, rectification of negative values, and non-overlapping max pooling. Any stage that is off is bypassed. With the right mode, one lane can act as a convolver, an element-wise adder, an element-wise multiplier (kernel width 1) or a subsampler.

All data is signed fixed point with `FRAC` fraction bits. Convolution products are summed in a wide accumulator, shifted right by `FRAC` and clamped to the data width. A `start` pulse latches the configuration: mode, kernel width, row width of the pre-pool matrix, pooling width and result count. The lane then accepts beats until it has issued the configured number of results. It drops `busy` once the last result has been taken. Window generation, kernel storage and result memory live outside this block.

Top module: `cpp_lane`

## Requirements
- R1: After reset `busy`, `out_valid` and `in_ready` are 0.
- R2: With mode bit 0 set, each element takes kw*kw beats (kernel width 0 acts as 1). The element value is the sum of `in_pix*in_wgt` over those beats, arithmetically shifted right by `FRAC`, then clamped to the signed `DW`-bit range.
- R3: With mode bit 0 clear, each element takes one beat and its value is `in_pix`. `in_wgt` has no effect.
- R4: With mode bit 1 set, the `in_acc` value presented on an element's last beat is added to the element. The sum is clamped to the signed `DW`-bit range.
- R5: With mode bit 2 set, negative values become 0. With it clear, values pass unchanged.
- R6: With mode bit 3 set, elements form a raster of rows that are src_w wide (0 means 256). One result is the maximum over a non-overlapping p-by-p region, and results come out in raster order. Columns left over past the last full group in a row are dropped. A pool width of 0 acts as 1, and a width above 8 acts as 8.
- R7: The stages apply in this order: convolution, addition, rectification, pooling.
- R8: Exactly `cfg_res_cnt` results are emitted, and a count of 0 emits none. After the last result is accepted, `busy` and `in_ready` are 0.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. No result is lost under input or output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch configuration and begin (ignored while busy) |
| cfg_mode | input | 4 | Stage enables: bit0 conv, bit1 add, bit2 rectify, bit3 pool |
| cfg_kern_w | input | 6 | Kernel width 0..32 |
| cfg_src_w | input | 8 | Pre-pool row width, 0 means 256 |
| cfg_pool_w | input | 4 | Pool region width 1..8 |
| cfg_res_cnt | input | 16 | Number of results to emit |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Lane accepts a beat |
| in_pix | input | DW | Window element |
| in_wgt | input | DW | Kernel element |
| in_acc | input | DW | Accumulation operand (used on an element's last beat) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_data | output | DW | Result element |
| busy | output | 1 | Run in progress |

## Verification
Random small operands with random valid and ready gaps exercise each single stage on its own and the full mode-15 chain. A mismatch there separates a wrong stage order or a wrong beat count from a handshake fault. Directed operands at the rails push the convolution and the addition into clamping, which tells a wrapping sum apart from a clamped one. Pooling is tried with a row width that is not a multiple of the pool width, which exposes wrong column grouping or a leaked leftover column. Kernel width 0 and a result count of 0 cover the degenerate configurations.

// File: rtl/cpp_pkg.sv
// Shared constants for the convolution post-processing lane.
// Assumes: mode word bit positions are fixed by the control software.
package cpp_pkg;
    localparam int MODE_CONV = 0;
    localparam int MODE_ADD  = 1;
    localparam int MODE_RELU = 2;
    localparam int MODE_POOL = 3;
endpackage

// File: rtl/cpp_mac.sv
// Multiply-accumulate over kw*kw beats per element, or single-beat bypass.
// Assumes: kern_w and conv_en are held constant between clear pulses.
module cpp_mac #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int KWB  = 6,
    localparam int ACCW = 2*DW + 2*KWB,
    localparam int CNTW = 2*KWB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          conv_en,
    input  logic [KWB-1:0] kern_w,
    input  logic          fire,
    input  logic [DW-1:0] pix,
    input  logic [DW-1:0] wgt,
    output logic          last,
    output logic [DW-1:0] res
);
    localparam logic signed [ACCW-1:0] HI = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] LO = ~HI;

    logic [KWB-1:0]          kw_eff;
    logic [CNTW-1:0]         kk;
    logic [CNTW-1:0]         beat;
    logic signed [ACCW-1:0]  acc;
    logic signed [2*DW-1:0]  prod;
    logic signed [ACCW-1:0]  total;
    logic signed [ACCW-1:0]  shifted;

    // Beats per element and end-of-element detection.
    always_comb begin
        kw_eff = (kern_w == '0) ? KWB'(1) : kern_w;
        kk     = conv_en ? CNTW'(kw_eff) * CNTW'(kw_eff) : CNTW'(1);
        last   = (beat == kk - CNTW'(1));
    end

    // Running sum including the current beat, scaled and clamped.
    always_comb begin
        prod    = $signed(pix) * $signed(wgt);
        total   = acc + ACCW'(prod);
        shifted = total >>> FRAC;
        if (!conv_en)          res = pix;
        else if (shifted > HI) res = HI[DW-1:0];
        else if (shifted < LO) res = LO[DW-1:0];
        else                   res = shifted[DW-1:0];
    end

    // Accumulator and beat counter advance on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc  <= '0;
            beat <= '0;
        end else if (fire) begin
            if (last) begin
                acc  <= '0;
                beat <= '0;
            end else begin
                acc  <= total;
                beat <= beat + CNTW'(1);
            end
        end
    end

    assert_beat_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat < kk);
endmodule

// File: rtl/cpp_pool.sv
// Non-overlapping p-by-p max pooling over a raster of src_w-wide rows.
// Assumes: pw_m1 and src_w are held between clear pulses; src_w 0 means 256.
module cpp_pool #(
    parameter int DW   = 16,
    parameter int MAXW = 256,
    localparam int AW  = $clog2(MAXW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [2:0]    pw_m1,
    input  logic [AW-1:0] src_w,
    input  logic          strobe,
    input  logic [DW-1:0] v,
    output logic          emit,
    output logic [DW-1:0] q
);
    logic [DW-1:0] rowbuf [MAXW];
    logic [AW-1:0] col, grp;
    logic [2:0]    sub, rsub;
    logic [DW-1:0] gmax, gm, merged, prev;
    logic          grp_done, row_end;

    // Running maximum within the current column group and row band.
    always_comb begin
        gm       = (sub == 3'd0 || $signed(v) > $signed(gmax)) ? v : gmax;
        prev     = rowbuf[grp];
        merged   = (rsub == 3'd0 || $signed(gm) > $signed(prev)) ? gm : prev;
        grp_done = (sub == pw_m1);
        row_end  = (col == src_w - AW'(1));
        emit     = strobe && grp_done && (rsub == pw_m1);
        q        = merged;
    end

    // Position counters for column, group and row band.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            col <= '0; grp <= '0; sub <= '0; rsub <= '0; gmax <= '0;
        end else if (strobe) begin
            gmax <= gm;
            if (grp_done) begin
                sub <= '0;
                grp <= grp + AW'(1);
            end else begin
                sub <= sub + 3'd1;
            end
            if (row_end) begin
                col  <= '0;
                sub  <= '0;
                grp  <= '0;
                rsub <= (rsub == pw_m1) ? 3'd0 : rsub + 3'd1;
            end else begin
                col <= col + AW'(1);
            end
        end
    end

    // Partial maxima of the current band, one per column group.
    always_ff @(posedge clk) begin
        if (strobe && grp_done) rowbuf[grp] <= merged;
    end

    assert_pool_counters_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sub <= pw_m1 && rsub <= pw_m1);
endmodule

// File: rtl/cpp_lane.sv
// Mode-configurable lane: conv -> add -> rectify -> pool, valid/ready output.
// Assumes: configuration inputs are only sampled on an accepted start pulse.
module cpp_lane #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int MAXW = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    cfg_mode,
    input  logic [5:0]    cfg_kern_w,
    input  logic [7:0]    cfg_src_w,
    input  logic [3:0]    cfg_pool_w,
    input  logic [15:0]   cfg_res_cnt,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_pix,
    input  logic [DW-1:0] in_wgt,
    input  logic [DW-1:0] in_acc,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          busy
);
    import cpp_pkg::*;

    logic [3:0]    mode_q;
    logic [5:0]    kw_q;
    logic [7:0]    sw_q;
    logic [2:0]    pm1_q;
    logic [15:0]   cnt_q, issued;
    logic          busy_q, ov_q;
    logic [DW-1:0] od_q;
    logic          go, active, fire, last, emit, pool_emit;
    logic [DW-1:0] mac_res, added, act, pool_q, val;
    logic signed [DW:0] sum;

    assign go        = start && !busy_q;
    assign active    = busy_q && (issued != cnt_q);
    assign in_ready  = active && (!ov_q || out_ready);
    assign fire      = in_valid && in_ready;
    assign out_valid = ov_q;
    assign out_data  = od_q;
    assign busy      = busy_q;

    cpp_mac #(.DW(DW), .FRAC(FRAC), .KWB(6)) u_mac (
        .clk(clk), .rst_n(rst_n), .clear(go), .conv_en(mode_q[MODE_CONV]),
        .kern_w(kw_q), .fire(fire), .pix(in_pix), .wgt(in_wgt),
        .last(last), .res(mac_res)
    );

    // Clamped operand addition followed by optional rectification.
    always_comb begin
        sum = {mac_res[DW-1], mac_res} + {in_acc[DW-1], in_acc};
        if (!mode_q[MODE_ADD])       added = mac_res;
        else if (sum[DW] != sum[DW-1]) added = sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else                         added = sum[DW-1:0];
        act = (mode_q[MODE_RELU] && added[DW-1]) ? '0 : added;
    end

    cpp_pool #(.DW(DW), .MAXW(MAXW)) u_pool (
        .clk(clk), .rst_n(rst_n), .clear(go), .pw_m1(pm1_q), .src_w(sw_q),
        .strobe(fire && last && mode_q[MODE_POOL]), .v(act),
        .emit(pool_emit), .q(pool_q)
    );

    // Pick the pooled or the direct element as the lane result.
    always_comb begin
        emit = mode_q[MODE_POOL] ? pool_emit : (fire && last);
        val  = mode_q[MODE_POOL] ? pool_q : act;
    end

    // Configuration latch and run control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; mode_q <= '0; kw_q <= '0; sw_q <= '0; pm1_q <= '0; cnt_q <= '0;
        end else if (go) begin
            busy_q <= (cfg_res_cnt != 16'd0);
            mode_q <= cfg_mode;
            kw_q   <= cfg_kern_w;
            sw_q   <= cfg_src_w;
            pm1_q  <= (cfg_pool_w == 4'd0) ? 3'd0 : (cfg_pool_w > 4'd8) ? 3'd7 : 3'(cfg_pool_w - 4'd1);
            cnt_q  <= cfg_res_cnt;
        end else if (busy_q && issued == cnt_q && (!ov_q || out_ready)) begin
            busy_q <= 1'b0;
        end
    end

    // Output register and issued-result counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0; od_q <= '0; issued <= '0;
        end else if (go) begin
            issued <= '0;
        end else if (emit) begin
            ov_q   <= 1'b1;
            od_q   <= val;
            issued <= issued + 16'd1;
        end else if (out_ready) begin
            ov_q <= 1'b0;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q && !out_ready |=> ov_q && $stable(od_q));
    assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issued <= cnt_q || !busy_q);
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !ov_q);
    assert_relu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q && mode_q[MODE_RELU] |-> !od_q[DW-1]);
endmodule

// File: tb/tb_cpp_lane.sv
module tb_cpp_lane;
    localparam int DW = 16, FRAC = 8;
    logic clk = 0, rst_n = 0, start = 0;
    logic [3:0] cfg_mode = 0; logic [5:0] cfg_kern_w = 0; logic [7:0] cfg_src_w = 0;
    logic [3:0] cfg_pool_w = 0; logic [15:0] cfg_res_cnt = 0;
    logic in_valid = 0, out_ready = 0;
    logic [DW-1:0] in_pix = 0, in_wgt = 0, in_acc = 0;
    logic in_ready, out_valid, busy;
    logic [DW-1:0] out_data;
    int compared = 0, mismatched = 0;
    int bpix[4096], bwgt[4096], eacc[1024], pre[1024], expv[1024];

    always #5 clk = ~clk;

    cpp_lane #(.DW(DW), .FRAC(FRAC)) dut (.*);

    function automatic int sat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(string req, int mode, int kw, int sw, int pw, int cnt,
                       int plo, int phi, int wlo, int whi, int alo, int ahi);
        int kk, p, swe, ow, nel, nb, idx, oi, cyc;
        logic hold; int held;
        kk  = mode[0] ? ((kw == 0) ? 1 : kw*kw) : 1;
        p   = (pw == 0) ? 1 : (pw > 8) ? 8 : pw;
        swe = (sw == 0) ? 256 : sw;
        ow  = swe / p;
        nel = mode[3] ? ((cnt + ow - 1) / ow) * p * swe : cnt;
        nb  = nel * kk;
        for (int i = 0; i < nb; i++) begin
            bpix[i] = $urandom_range(phi - plo) + plo;
            bwgt[i] = $urandom_range(whi - wlo) + wlo;
        end
        for (int e = 0; e < nel; e++) begin
            longint s = 0;
            int v;
            eacc[e] = $urandom_range(ahi - alo) + alo;
            for (int j = 0; j < kk; j++) s += longint'(bpix[e*kk+j]) * longint'(bwgt[e*kk+j]);
            v = mode[0] ? sat(s >>> FRAC) : bpix[e*kk];
            if (mode[1]) v = sat(longint'(v) + eacc[e]);
            if (mode[2] && v < 0) v = 0;
            pre[e] = v;
        end
        for (int i = 0; i < cnt; i++) begin
            if (mode[3]) begin
                int pr = i / ow, pc = i % ow, m;
                m = pre[pr*p*swe + pc*p];
                for (int a = 0; a < p; a++)
                    for (int b = 0; b < p; b++)
                        if (pre[(pr*p+a)*swe + pc*p + b] > m) m = pre[(pr*p+a)*swe + pc*p + b];
                expv[i] = m;
            end else expv[i] = pre[i];
        end
        @(negedge clk);
        cfg_mode = 4'(mode); cfg_kern_w = 6'(kw); cfg_src_w = 8'(sw);
        cfg_pool_w = 4'(pw); cfg_res_cnt = 16'(cnt); start = 1;
        @(negedge clk);
        start = 0;
        idx = 0; oi = 0; cyc = 0; hold = 0; held = 0;
        do begin
            if (hold) begin
                check({req, " R9 hold"}, {31'd0, out_valid} + (out_data == DW'(held) ? 0 : 2), 1);
            end
            in_valid  = (idx < nb) && ($urandom_range(3) != 0);
            in_pix    = DW'(bpix[idx]); in_wgt = DW'(bwgt[idx]); in_acc = DW'(eacc[idx / kk]);
            out_ready = ($urandom_range(2) != 0);
            #1;
            hold = out_valid && !out_ready;
            held = int'(out_data);
            if (out_valid && out_ready) begin
                if (oi < cnt) check(req, int'($signed(out_data)), expv[oi]);
                else check({req, " R8 extra"}, oi, cnt - 1);
                oi++;
            end
            if (in_valid && in_ready) idx++;
            cyc++;
            @(negedge clk);
            in_valid = 0;
        end while (busy && cyc < 20000);
        if (cyc >= 20000) check({req, " watchdog"}, cyc, 0);
        check({req, " R8 count"}, oi, cnt);
        #1;
        check({req, " R8 idle"}, {30'd0, busy, in_ready}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check("R1 reset", {29'd0, busy, out_valid, in_ready}, 0);
        rst_n = 1;
        run("R2 conv k3",     1, 3, 0, 0, 12, -1000, 1000, -300, 300, 0, 0);
        run("R2 kw0",         1, 0, 0, 0, 8, -1000, 1000, -300, 300, 0, 0);
        run("R2 conv clamp",  1, 2, 0, 0, 3, 32767, 32767, 32767, 32767, 0, 0);
        run("R2 conv clamp-", 1, 2, 0, 0, 3, -32768, -32768, 32767, 32767, 0, 0);
        run("R3 bypass",      0, 4, 0, 0, 10, -30000, 30000, -30000, 30000, 0, 0);
        run("R4 add",         2, 1, 0, 0, 10, -1000, 1000, 0, 0, -1000, 1000);
        run("R4 add clamp",   2, 1, 0, 0, 4, 32000, 32767, 0, 0, 800, 1000);
        run("R5 relu",        4, 1, 0, 0, 12, -500, 500, 0, 0, 0, 0);
        run("R6 pool p3 w7",  8, 1, 7, 3, 4, -1000, 1000, 0, 0, 0, 0);
        run("R6 pool p0",     8, 1, 5, 0, 6, -1000, 1000, 0, 0, 0, 0);
        run("R7 mode15",      15, 2, 6, 2, 6, -600, 600, -300, 300, -2000, 2000);
        run("R7 conv+relu",   5, 2, 0, 0, 8, -600, 600, -300, 300, 0, 0);
        run("R8 zero count",  1, 3, 0, 0, 0, -100, 100, -100, 100, 0, 0);
        run("R8 k1 product",  1, 1, 0, 0, 20, -2000, 2000, -2000, 2000, 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule